// File: doc/BRIEF.md
# Segmented Bounded Program Counter

This block takes the place of a free-running program counter in a small security processor. The counter is split into a wide segment register and a short offset counter. The fetch address is always the sum of the two. An ordinary instruction step advances only the offset. Any control transfer (jump, call or return) loads its destination into the segment register and clears the offset.

The offset never wraps. A step that arrives while the offset is already at its ceiling does not advance it. Instead the block issues a one-cycle reset request to the processor and returns both registers to zero. As a result, straight-line fetching can cover at most 2^OFS_W - 1 addresses past the last branch target, and an attacker cannot use the counter as a free address sweeper.

The adder can be built behaviourally or as an explicit ripple chain, chosen by a parameter. Both variants give the same modulo-2^ADDR_W result.

Top module: `seg_pc_guard`

## Requirements
- R1: While rst_ni is low, and in the first cycle after it rises, fetch_addr_o is 0x0000 and reset_req_o is 0.
- R2: fetch_addr_o always equals segment + offset modulo 2^16, where the segment is the last branch target (or 0) and the offset is the number of steps taken since then.
- R3: A cycle with step_i=1, branch_i=0 and an offset below 127 makes fetch_addr_o one higher (mod 2^16) after the next rising edge.
- R4: A cycle with branch_i=1 makes fetch_addr_o equal to that cycle's target_i after the next rising edge.
- R5: When branch_i=1 and step_i=1 arrive in the same cycle, the branch wins and no reset request is raised, even with the offset at 127.
- R6: A step with branch_i=0 while the offset is 127 raises reset_req_o after the next rising edge and sets fetch_addr_o to 0x0000.
- R7: reset_req_o is high for exactly one cycle per overflow.
- R8: A cycle with step_i=0 and branch_i=0 leaves fetch_addr_o unchanged.
- R9: Exactly 127 consecutive steps after a branch raise no reset and end at target+127.
- R10: A segment near the top of the address space wraps: target 0xFFF0 followed by 20 steps gives 0x0004.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| step_i | input | 1 | Advance offset by one (active high) |
| branch_i | input | 1 | Control transfer taken (active high) |
| target_i | input | 16 | Destination of the control transfer |
| fetch_addr_o | output | 16 | Segment plus offset |
| reset_req_o | output | 1 | One-cycle processor reset request |

## Verification
The bench goes after the offset ceiling from both sides. Step 127 must pass quietly, and a design that traps one step early would pulse the reset there. Step 128 must trap, and a design that wraps would instead show target+0 with no pulse. A branch coinciding with a step at the ceiling is driven directly: a design with the wrong priority would pulse reset or jump to zero instead of the target. A segment just below 0xFFFF checks that the sum wraps rather than saturates. Long random runs with rare branches hit many overflows and pulse widths.

// File: rtl/seg_pc_pkg.sv
package seg_pc_pkg;
   typedef enum logic [1:0] {
      ACT_HOLD = 2'd0,
      ACT_STEP = 2'd1,
      ACT_LOAD = 2'd2,
      ACT_TRAP = 2'd3
   } pc_act_e;
endpackage

// File: rtl/seg_pc_ctrl.sv
module seg_pc_ctrl
   import seg_pc_pkg::*;
(
   input  logic    clk_i,
   input  logic    rst_ni,
   input  logic    step_i,
   input  logic    branch_i,
   input  logic    at_max_i,
   output pc_act_e act_o,
   output logic    trap_q_o
);
   always_comb begin
      if (branch_i)
         act_o = ACT_LOAD;
      else if (step_i && at_max_i)
         act_o = ACT_TRAP;
      else if (step_i)
         act_o = ACT_STEP;
      else
         act_o = ACT_HOLD;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
         trap_q_o <= 1'b0;
      else
         trap_q_o <= (act_o == ACT_TRAP);
   end

   // R5: a taken branch never yields a reset pulse
   assert_branch_no_trap_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      branch_i |=> !trap_q_o);
   // R7: pulse is a single cycle
   assert_pulse_single_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      trap_q_o |=> !trap_q_o);
endmodule

// File: rtl/seg_pc_segreg.sv
module seg_pc_segreg
   import seg_pc_pkg::*;
#(
   parameter int ADDR_W = 16
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  pc_act_e           act_i,
   input  logic [ADDR_W-1:0] target_i,
   output logic [ADDR_W-1:0] seg_o
);
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
         seg_o <= '0;
      else if (act_i == ACT_LOAD)
         seg_o <= target_i;
      else if (act_i == ACT_TRAP)
         seg_o <= '0;
   end

   // R4: segment takes the target on a load
   assert_seg_load_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (act_i == ACT_LOAD) |=> (seg_o == $past(target_i)));
endmodule

// File: rtl/seg_pc_offset.sv
module seg_pc_offset
   import seg_pc_pkg::*;
#(
   parameter int OFS_W = 7
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  pc_act_e          act_i,
   output logic [OFS_W-1:0] ofs_o,
   output logic             at_max_o
);
   localparam logic [OFS_W-1:0] OFS_MAX = {OFS_W{1'b1}};

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
         ofs_o <= '0;
      else begin
         unique case (act_i)
            ACT_STEP: ofs_o <= ofs_o + 1'b1;
            ACT_LOAD,
            ACT_TRAP: ofs_o <= '0;
            default:  ofs_o <= ofs_o;
         endcase
      end
   end

   assign at_max_o = (ofs_o == OFS_MAX);

   // R3: a plain step advances the offset by one
   assert_ofs_inc_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (act_i == ACT_STEP) |=> (ofs_o == $past(ofs_o) + 1'b1));
   // R6: offset at the ceiling never wraps by stepping
   assert_no_wrap_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (at_max_o && act_i != ACT_LOAD && act_i != ACT_TRAP) |=> at_max_o);
endmodule

// File: rtl/seg_pc_adder.sv
module seg_pc_adder #(
   parameter int ADDR_W = 16,
   parameter int OFS_W  = 7,
   parameter bit RIPPLE = 1'b0
) (
   input  logic [ADDR_W-1:0] seg_i,
   input  logic [OFS_W-1:0]  ofs_i,
   output logic [ADDR_W-1:0] sum_o
);
   localparam int PAD_W = ADDR_W - OFS_W;
   logic [ADDR_W-1:0] ofs_ext;
   assign ofs_ext = {{PAD_W{1'b0}}, ofs_i};

   generate
      if (RIPPLE) begin : g_ripple
         logic [ADDR_W-1:0] carry;
         assign carry[0] = 1'b0;
         for (genvar i = 0; i < ADDR_W; i++) begin : g_bit
            assign sum_o[i] = seg_i[i] ^ ofs_ext[i] ^ carry[i];
            if (i < ADDR_W - 1) begin : g_c
               assign carry[i+1] = (seg_i[i] & ofs_ext[i]) |
                                   (carry[i] & (seg_i[i] ^ ofs_ext[i]));
            end
         end
      end else begin : g_behav
         assign sum_o = seg_i + ofs_ext;
      end
   endgenerate
endmodule

// File: rtl/seg_pc_guard.sv
module seg_pc_guard
   import seg_pc_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int OFS_W  = 7,
   parameter bit RIPPLE = 1'b0
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              step_i,
   input  logic              branch_i,
   input  logic [ADDR_W-1:0] target_i,
   output logic [ADDR_W-1:0] fetch_addr_o,
   output logic              reset_req_o
);
   generate
      if (OFS_W < 1 || OFS_W >= ADDR_W) begin : g_bad_ofs
         $error("seg_pc_guard: OFS_W must be in 1..ADDR_W-1");
      end
      if (ADDR_W < 2) begin : g_bad_addr
         $error("seg_pc_guard: ADDR_W must be at least 2");
      end
   endgenerate

   pc_act_e           act;
   logic              at_max;
   logic [ADDR_W-1:0] seg;
   logic [OFS_W-1:0]  ofs;

   seg_pc_ctrl u_ctrl (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .step_i   (step_i),
      .branch_i (branch_i),
      .at_max_i (at_max),
      .act_o    (act),
      .trap_q_o (reset_req_o)
   );

   seg_pc_segreg #(.ADDR_W(ADDR_W)) u_seg (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .act_i    (act),
      .target_i (target_i),
      .seg_o    (seg)
   );

   seg_pc_offset #(.OFS_W(OFS_W)) u_ofs (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .act_i    (act),
      .ofs_o    (ofs),
      .at_max_o (at_max)
   );

   seg_pc_adder #(.ADDR_W(ADDR_W), .OFS_W(OFS_W), .RIPPLE(RIPPLE)) u_add (
      .seg_i (seg),
      .ofs_i (ofs),
      .sum_o (fetch_addr_o)
   );

   // R4: branch lands on the target at the port
   assert_branch_addr_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      branch_i |=> (fetch_addr_o == $past(target_i)));
   // R3: a step below the ceiling adds one to the fetch address
   assert_step_addr_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (step_i && !branch_i && !at_max) |=>
         (fetch_addr_o == $past(fetch_addr_o) + 1'b1));
   // R6: overflow step traps and returns to address zero
   assert_trap_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (step_i && !branch_i && at_max) |=> (reset_req_o && fetch_addr_o == '0));
   // R8: idle cycles hold the address
   assert_idle_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!step_i && !branch_i) |=> $stable(fetch_addr_o));
endmodule

// File: tb/seg_pc_guard_tb_top.sv
module seg_pc_guard_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        step = 1'b0;
   logic        branch = 1'b0;
   logic [15:0] target = '0;
   logic [15:0] addr;
   logic        rreq;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   logic [15:0] m_seg = '0;
   logic [6:0]  m_ofs = '0;
   logic        m_rst = 1'b0;

   always #5 clk = ~clk;

   seg_pc_guard dut_i (
      .clk_i(clk), .rst_ni(rst_n), .step_i(step), .branch_i(branch),
      .target_i(target), .fetch_addr_o(addr), .reset_req_o(rreq)
   );

   function automatic logic [15:0] exp_addr(logic [15:0] s, logic [6:0] o);
      return s + {9'd0, o};
   endfunction

   task automatic model(input logic st, input logic br, input logic [15:0] tg);
      m_rst = 1'b0;
      if (br) begin
         m_seg = tg; m_ofs = '0;
      end else if (st && m_ofs == 7'd127) begin
         m_seg = '0; m_ofs = '0; m_rst = 1'b1;
      end else if (st) begin
         m_ofs = m_ofs + 7'd1;
      end
   endtask

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic tick(input logic st, input logic br, input logic [15:0] tg, input string req);
      @(negedge clk);
      step = st; branch = br; target = tg;
      @(posedge clk);
      model(st, br, tg);
      #1;
      chk({req, " addr"}, addr, exp_addr(m_seg, m_ofs));
      chk({req, " rreq"}, {15'd0, rreq}, {15'd0, m_rst});
   endtask

   initial begin
      void'($urandom(32'd4242));
      repeat (3) @(posedge clk);
      #1;
      chk("R1 reset addr", addr, 16'h0000);
      chk("R1 reset rreq", {15'd0, rreq}, 16'd0);
      @(negedge clk);
      rst_n = 1'b1;
      tick(1'b0, 1'b0, 16'h0, "R1 first");
      tick(1'b0, 1'b1, 16'h1234, "R4 branch");
      tick(1'b1, 1'b0, 16'h0, "R3 step");
      tick(1'b0, 1'b0, 16'hBEEF, "R8 idle");
      tick(1'b0, 1'b1, 16'h4000, "R4 branch2");
      for (int i = 0; i < 126; i++) tick(1'b1, 1'b0, 16'h0, "R9 steps");
      tick(1'b1, 1'b0, 16'h0, "R9 step127");
      chk("R9 end addr", addr, 16'h407F);
      tick(1'b1, 1'b0, 16'h0, "R6 overflow");
      chk("R6 pulse", {15'd0, rreq}, 16'd1);
      chk("R6 zero addr", addr, 16'h0000);
      tick(1'b0, 1'b0, 16'h0, "R7 pulse end");
      chk("R7 pulse low", {15'd0, rreq}, 16'd0);
      for (int i = 0; i < 127; i++) tick(1'b1, 1'b0, 16'h0, "R2 climb");
      tick(1'b1, 1'b1, 16'h2222, "R5 priority");
      chk("R5 target", addr, 16'h2222);
      chk("R5 no pulse", {15'd0, rreq}, 16'd0);
      tick(1'b0, 1'b1, 16'hFFF0, "R10 branch");
      for (int i = 0; i < 20; i++) tick(1'b1, 1'b0, 16'h0, "R10 wrap");
      chk("R10 wrapped", addr, 16'h0004);
      for (int i = 0; i < 4000; i++) begin
         logic st, br;
         st = ($urandom % 10) < 9;
         br = ($urandom % 200) == 0;
         tick(st, br, 16'($urandom), "R2 random");
      end
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            #1_500_000ns;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule